// File: doc/BRIEF.md
# Display Palette Lookup Memory

This block is the colour lookup table of a display controller. It holds 256 palette entries of 16 bits each, kept as 128 words of 32 bits, so each word carries two entries. On the bus side, software writes and reads the table one 32-bit word at a time. Per-byte write enables allow a single entry, or part of one, to change without touching its neighbour.

On the pixel side, the pixel pipeline supplies an 8-bit index with a valid strobe. Index bits 7:1 pick the word and bit 0 picks one half of it. The byte-order mode sets which half bit 0 selects. The chosen entry is split into its colour components and each is cut to its upper four bits. The red and blue components can be exchanged for panels that expect BGR order. In monochrome mode only the red component is passed on.

The two ports have separate addresses and controls and work in the same cycle. Each port has one cycle of registered read latency. When both ports touch one word in the same cycle, the read returns the contents from before the write.

Top module: `pal_lookup`

## Requirements
- R1: After a cycle with rst_n low, out_valid is 0, out_red, out_green and out_blue are 0, and bus_rdata is 0.
- R2: bus_rdata shows the word at bus_addr one cycle after bus_addr is presented. A word written with bus_be = 4'hF reads back unchanged.
- R3: On a write, bus_be[k] enables bits 8k+7:8k of the word at bus_addr. Lanes whose enable is 0 keep their previous contents.
- R4: With mode_big_endian = 0, pix_index[0] = 1 selects word bits 31:16 and pix_index[0] = 0 selects bits 15:0. The word is pix_index[7:1].
- R5: With mode_big_endian = 1, pix_index[0] = 1 selects word bits 15:0 and pix_index[0] = 0 selects bits 31:16.
- R6: An entry holds red in bits 4:0, green in bits 9:5 and blue in bits 14:10, with bit 15 unused. With mode_color = 1, out_red, out_green and out_blue carry bits 4:1 of the red, green and blue components.
- R7: With mode_color = 0 (monochrome), out_red carries bits 4:1 of the red component and out_green and out_blue are 0.
- R8: With mode_bgr = 1, the red and blue components are exchanged before the mode_color selection. In monochrome mode, out_red then carries blue bits 4:1.
- R9: out_valid is 1 exactly in the cycle after pix_valid was 1. When out_valid is 0, all three colour outputs are 0. The mode inputs are sampled together with pix_index.
- R10: A pixel read or bus read of a word that the bus writes in the same cycle returns the old contents. The new contents are returned for a read in the following cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_addr | input | 7 | Bus word address |
| bus_wdata | input | 32 | Bus write data, two entries |
| bus_we | input | 1 | Bus write strobe |
| bus_be | input | 4 | Bus byte enables |
| bus_rdata | output | 32 | Registered bus read data |
| pix_valid | input | 1 | Pixel lookup request |
| pix_index | input | 8 | Pixel palette index |
| mode_big_endian | input | 1 | Half-select polarity, 1 = big-endian |
| mode_bgr | input | 1 | Exchange red and blue |
| mode_color | input | 1 | 1 = colour panel, 0 = monochrome |
| out_valid | output | 1 | Colour outputs valid |
| out_red | output | 4 | Red output, bits 4:1 |
| out_green | output | 4 | Green output, bits 4:1 |
| out_blue | output | 4 | Blue output, bits 4:1 |

## Verification
The properties assume that rst_n is held low for at least one clock edge before use. They also assume that every input is settled at the sampling edge, including the mode inputs, which are treated as part of each pixel request. The bus read-back property also assumes that no write comes between a full-word write and the read of the same address. The stimulus drives every input on the falling edge only. It writes the whole table with known data before any pixel read, and in each random step it holds back the bus write whenever that step checks a bus read-back.

// File: rtl/pal_pkg.sv
// Package: shared types and sizes for the palette lookup.
// Assumes 16-bit entries with three 5-bit components and one spare bit.
package pal_pkg;
    localparam int ENTRY_W = 16;
    localparam int COMP_W  = 5;
    localparam int OUT_W   = 4;

    // One palette entry, most significant field first.
    typedef struct packed {
        logic              spare;
        logic [COMP_W-1:0] blue;
        logic [COMP_W-1:0] green;
        logic [COMP_W-1:0] red;
    } pal_entry_t;

    // Control flags captured alongside a pixel request.
    typedef struct packed {
        logic valid;
        logic idx_lsb;
        logic big_endian;
        logic bgr;
        logic color;
    } pix_ctl_t;
endpackage

// File: rtl/pal_store.sv
// Module: two-port word store, split into byte lanes.
// Port A reads and writes (with byte enables); port B only reads.
// Both reads are registered and return pre-write data on a collision.
// Assumes the contents are written before they are read; storage is not reset.
module pal_store #(
    parameter int WORDS = 128,
    parameter int DW    = 32,
    localparam int AW    = $clog2(WORDS),
    localparam int LANES = DW / 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [AW-1:0]    a_addr,
    input  logic [DW-1:0]    a_wdata,
    input  logic             a_we,
    input  logic [LANES-1:0] a_be,
    output logic [DW-1:0]    a_rdata,
    input  logic [AW-1:0]    b_addr,
    input  logic             b_en,
    output logic [DW-1:0]    b_rdata
);
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [7:0] cells [WORDS];
        logic [7:0] a_q;
        logic [7:0] b_q;

        // Write this lane when its byte enable is set.
        always_ff @(posedge clk) begin
            if (a_we && a_be[g]) begin
                cells[a_addr] <= a_wdata[8*g +: 8];
            end
        end

        // Port A read register: every cycle, old data on a collision.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                a_q <= '0;
            end else begin
                a_q <= cells[a_addr];
            end
        end

        // Port B read register: only on a request, old data on a collision.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                b_q <= '0;
            end else if (b_en) begin
                b_q <= cells[b_addr];
            end
        end

        assign a_rdata[8*g +: 8] = a_q;
        assign b_rdata[8*g +: 8] = b_q;
    end
endmodule

// File: rtl/pal_pix_stage.sv
// Module: registers the pixel request controls so that they line up
// with the registered word from the store. Reset clears valid.
module pal_pix_stage (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_lsb,
    input  logic              req_big,
    input  logic              req_bgr,
    input  logic              req_color,
    output pal_pkg::pix_ctl_t ctl_q
);
    // Capture the controls of the request alongside the word read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else begin
            ctl_q.valid      <= req_valid;
            ctl_q.idx_lsb    <= req_lsb;
            ctl_q.big_endian <= req_big;
            ctl_q.bgr        <= req_bgr;
            ctl_q.color      <= req_color;
        end
    end
endmodule

// File: rtl/pal_format.sv
// Module: combinational output shaping. It selects a half of the word,
// exchanges red and blue if asked, and truncates each component to its top
// bits. Monochrome mode and an idle stage force the unused outputs to zero.
module pal_format
    import pal_pkg::*;
#(
    localparam int DW = 2 * ENTRY_W
) (
    input  logic [DW-1:0]    word_q,
    input  pix_ctl_t         ctl_q,
    output logic             out_valid,
    output logic [OUT_W-1:0] out_red,
    output logic [OUT_W-1:0] out_green,
    output logic [OUT_W-1:0] out_blue
);
    pal_entry_t        entry;
    logic [COMP_W-1:0] c_red;
    logic [COMP_W-1:0] c_blue;
    logic              take_upper;

    // Choose the half; big-endian mode inverts the index LSB.
    always_comb begin
        take_upper = ctl_q.idx_lsb ^ ctl_q.big_endian;
        entry      = take_upper ? pal_entry_t'(word_q[DW-1:ENTRY_W])
                                : pal_entry_t'(word_q[ENTRY_W-1:0]);
    end

    // Apply the red/blue exchange, then the panel mode and the valid gate.
    always_comb begin
        c_red     = ctl_q.bgr ? entry.blue : entry.red;
        c_blue    = ctl_q.bgr ? entry.red  : entry.blue;
        out_valid = ctl_q.valid;
        out_red   = '0;
        out_green = '0;
        out_blue  = '0;
        if (ctl_q.valid) begin
            out_red = c_red[COMP_W-1 -: OUT_W];
            if (ctl_q.color) begin
                out_green = entry.green[COMP_W-1 -: OUT_W];
                out_blue  = c_blue[COMP_W-1 -: OUT_W];
            end
        end
    end
endmodule

// File: rtl/pal_lookup.sv
// Module: top of the palette lookup. It joins the byte-lane store, the pixel
// control stage and the output shaping. Assumes one clock and a synchronous
// active-low reset; the palette contents are not cleared by reset.
module pal_lookup
    import pal_pkg::*;
#(
    parameter int IDX_W = 8,
    localparam int WAW   = IDX_W - 1,
    localparam int WORDS = 1 << WAW,
    localparam int DW    = 2 * ENTRY_W,
    localparam int BEW   = DW / 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WAW-1:0]   bus_addr,
    input  logic [DW-1:0]    bus_wdata,
    input  logic             bus_we,
    input  logic [BEW-1:0]   bus_be,
    output logic [DW-1:0]    bus_rdata,
    input  logic             pix_valid,
    input  logic [IDX_W-1:0] pix_index,
    input  logic             mode_big_endian,
    input  logic             mode_bgr,
    input  logic             mode_color,
    output logic             out_valid,
    output logic [OUT_W-1:0] out_red,
    output logic [OUT_W-1:0] out_green,
    output logic [OUT_W-1:0] out_blue
);
    logic [DW-1:0] pix_word;
    pix_ctl_t      pix_ctl;

    pal_store #(.WORDS(WORDS), .DW(DW)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .a_addr  (bus_addr),
        .a_wdata (bus_wdata),
        .a_we    (bus_we),
        .a_be    (bus_be),
        .a_rdata (bus_rdata),
        .b_addr  (pix_index[IDX_W-1:1]),
        .b_en    (pix_valid),
        .b_rdata (pix_word)
    );

    pal_pix_stage u_stage (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (pix_valid),
        .req_lsb   (pix_index[0]),
        .req_big   (mode_big_endian),
        .req_bgr   (mode_bgr),
        .req_color (mode_color),
        .ctl_q     (pix_ctl)
    );

    pal_format u_format (
        .word_q    (pix_word),
        .ctl_q     (pix_ctl),
        .out_valid (out_valid),
        .out_red   (out_red),
        .out_green (out_green),
        .out_blue  (out_blue)
    );
endmodule

// File: rtl/pal_lookup_chk.sv
// Checker: timing properties of the palette lookup, seen at its ports.
// Assumes that reset is applied at least once before use.
module pal_lookup_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [6:0]  bus_addr,
    input logic [31:0] bus_wdata,
    input logic        bus_we,
    input logic [3:0]  bus_be,
    input logic [31:0] bus_rdata,
    input logic        pix_valid,
    input logic [7:0]  pix_index,
    input logic        mode_big_endian,
    input logic        mode_bgr,
    input logic        mode_color,
    input logic        out_valid,
    input logic [3:0]  out_red,
    input logic [3:0]  out_green,
    input logic [3:0]  out_blue
);
    // R9: the valid flag follows the request by exactly one cycle.
    a_r9_valid_delay: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> out_valid == $past(pix_valid));

    // R9: an idle output stage drives zero colours.
    a_r9_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> (out_red == 4'd0 && out_green == 4'd0 && out_blue == 4'd0));

    // R7: monochrome results carry no green or blue.
    a_r7_mono_zero: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && out_valid && !$past(mode_color))
        |-> (out_green == 4'd0 && out_blue == 4'd0));

    // R2: a full-word write reads back from the same address.
    a_r2_readback: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_be == 4'hF) ##1 (bus_addr == $past(bus_addr) && !bus_we)
        |=> bus_rdata == $past(bus_wdata, 2));

    // R1: reset clears the bus read register.
    a_r1_reset_rdata: assert property (@(posedge clk)
        !rst_n |=> bus_rdata == 32'd0);
endmodule

bind pal_lookup pal_lookup_chk u_chk (.*);

// File: tb/tb_pal_lookup.sv
module tb_pal_lookup;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [6:0]  bus_addr;
    logic [31:0] bus_wdata;
    logic        bus_we;
    logic [3:0]  bus_be;
    logic [31:0] bus_rdata;
    logic        pix_valid;
    logic [7:0]  pix_index;
    logic        mode_big_endian, mode_bgr, mode_color;
    logic        out_valid;
    logic [3:0]  out_red, out_green, out_blue;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;
    logic [31:0] model [128];

    always #2 clk = ~clk;

    pal_lookup dut (.*);

    // Expected 12-bit {red, green, blue} result for a lookup, from the requirements.
    function automatic logic [11:0] expect_pix(logic [31:0] w, logic [7:0] idx,
                                               logic big, logic bgr, logic col);
        logic [15:0] e;
        logic [4:0]  r, g, b, t;
        logic        upper;
        upper = big ? ~idx[0] : idx[0];
        e = upper ? w[31:16] : w[15:0];
        r = e[4:0]; g = e[9:5]; b = e[14:10];
        if (bgr) begin t = r; r = b; b = t; end
        if (col) return {r[4:1], g[4:1], b[4:1]};
        return {r[4:1], 8'd0};
    endfunction

    function automatic logic [31:0] lane_mask(logic [3:0] be);
        logic [31:0] m;
        for (int k = 0; k < 4; k++) m[8*k +: 8] = {8{be[k]}};
        return m;
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic idle();
        bus_we = 0; bus_be = 0; pix_valid = 0;
    endtask

    task automatic bus_write(logic [6:0] a, logic [31:0] d, logic [3:0] be);
        bus_addr = a; bus_wdata = d; bus_we = 1; bus_be = be;
        @(posedge clk); @(negedge clk);
        model[a] = (model[a] & ~lane_mask(be)) | (d & lane_mask(be));
        idle();
    endtask

    task automatic bus_read(string req, logic [6:0] a);
        bus_addr = a; bus_we = 0;
        @(posedge clk); @(negedge clk);
        check(req, bus_rdata, model[a]);
    endtask

    task automatic pix(string req, logic [7:0] idx, logic big, logic bgr, logic col);
        pix_valid = 1; pix_index = idx;
        mode_big_endian = big; mode_bgr = bgr; mode_color = col;
        @(posedge clk); @(negedge clk);
        check(req, {19'd0, out_valid, out_red, out_green, out_blue},
              {19'd0, 1'b1, expect_pix(model[idx[7:1]], idx, big, bgr, col)});
        pix_valid = 0;
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] old_w;
        void'($urandom(32'd1234));
        rst_n = 0; idle(); bus_addr = 0; bus_wdata = 0; pix_index = 0;
        mode_big_endian = 0; mode_bgr = 0; mode_color = 1;
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1: reset state, sampled before any new edge
        check("R1", {19'd0, out_valid, out_red, out_green, out_blue}, 32'd0);
        check("R1 rdata", bus_rdata, 32'd0);

        // Fill the table (R2)
        for (int i = 0; i < 128; i++) bus_write(i[6:0], $urandom(), 4'hF);
        bus_read("R2", 7'd0);
        bus_read("R2", 7'd127);

        // Directed field layout (R6) and half polarity (R4, R5)
        bus_write(7'd5, {1'b0, 5'h1E, 5'h0A, 5'h11, 1'b1, 5'h03, 5'h15, 5'h1C}, 4'hF);
        pix("R4 upper", 8'd11, 0, 0, 1);
        pix("R4 lower", 8'd10, 0, 0, 1);
        pix("R5 lower", 8'd11, 1, 0, 1);
        pix("R5 upper", 8'd10, 1, 0, 1);
        pix("R6 fields", 8'd10, 0, 0, 1);
        pix("R7 mono", 8'd10, 0, 0, 0);
        pix("R8 swap", 8'd11, 0, 1, 1);
        pix("R8 mono swap", 8'd10, 0, 1, 0);

        // R3: partial lane writes
        bus_write(7'd9, 32'hFFFF_FFFF, 4'hF);
        bus_write(7'd9, 32'h1234_5678, 4'b0101);
        bus_read("R3", 7'd9);
        check("R3 value", model[9], 32'hFF34_FF78);
        bus_write(7'd9, 32'h0, 4'b0000);
        bus_read("R3 none", 7'd9);

        // R9: idle stage drives zeros, valid drops
        @(posedge clk); @(negedge clk);
        check("R9 idle", {19'd0, out_valid, out_red, out_green, out_blue}, 32'd0);

        // R10: collision returns old contents, then new
        old_w = model[20];
        bus_addr = 7'd20; bus_wdata = ~old_w; bus_we = 1; bus_be = 4'hF;
        pix_valid = 1; pix_index = 8'd41; mode_big_endian = 0; mode_bgr = 0; mode_color = 1;
        @(posedge clk); @(negedge clk);
        check("R10 pixel old", {20'd0, out_red, out_green, out_blue},
              {20'd0, expect_pix(old_w, 8'd41, 0, 0, 1)});
        check("R10 bus old", bus_rdata, old_w);
        model[20] = ~old_w;
        idle();
        pix("R10 pixel new", 8'd41, 0, 0, 1);
        bus_read("R10 bus new", 7'd20);

        // Random mix (R2..R9)
        for (int it = 0; it < 400; it++) begin
            if ($urandom_range(0, 3) == 0) begin
                bus_write($urandom_range(0, 127), $urandom(), $urandom_range(0, 15));
            end else if ($urandom_range(0, 2) == 0) begin
                bus_read("R2 rand", $urandom_range(0, 127));
            end else begin
                pix("R6 rand", $urandom_range(0, 255), $urandom_range(0, 1),
                    $urandom_range(0, 1), $urandom_range(0, 1));
            end
        end

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end
endmodule